// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block collects the interrupt causes of a serial port and turns them into a single level interrupt. The FIFO logic supplies six level flags. Three describe the receive side: full, empty, and at or above its trigger level. Three describe the transmit side: full, empty, and at or above its trigger level. The block also takes single-cycle event pulses from the framing and control logic. These report receive overrun, framing error, parity error, receive timeout, modem status change and transmit overrun.

Every clock, the level flags and the event pulses are folded into a sticky cause register. Software clears that register by writing ones. A separate mask selects which causes may raise the interrupt line. Software changes the mask only through a write-to-set address and a write-to-clear address. The mask can be read back at its own address, and writes to that address have no effect. A read port also returns the live flag word. In the live word the transmit-trigger flag sits at a different bit than in the sticky word.

The register port is plain and has no handshake. The address input carries the word index, which is the byte offset divided by four. A write is one cycle with `bus_wr_i` high. Read data is a combinational function of the address.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Reading word index 0x0B (byte 0x2C) returns the live flag word. Receive-trigger is at bit 0, receive-empty at bit 1, receive-full at bit 2, transmit-empty at bit 3, transmit-full at bit 4 and transmit-trigger at bit 13. All other bits read zero.
- R2: On every clock, each of the live bits 4..0 that is high sets the same bit of the sticky register. The result is visible from the next cycle, at word index 0x05 (byte 0x14).
- R3: The live transmit-trigger flag (live bit 13) sets sticky bit 10.
- R4: A one-cycle event pulse sets a sticky bit from the next cycle. Receive overrun sets bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem status bit 9 and transmit overrun bit 12.
- R5: A write to word index 0x02 (byte 0x08) ORs the write data into the mask.
- R6: A write to word index 0x03 (byte 0x0C) clears every mask bit where the write data is one.
- R7: A write to the mask's own word index 0x04 (byte 0x10) leaves the mask unchanged. The mask reads back at that index.
- R8: Writing to the sticky register clears the bits written as one and leaves the others unchanged.
- R9: When a clear and a new set hit the same sticky bit in the same cycle, the bit ends up set.
- R10: `irq_o` is high exactly when some bit is set in both the mask and the sticky register.
- R11: While reset is asserted and right after it, the mask and sticky registers read zero and `irq_o` is low.
- R12: Reads of the enable index, the disable index and any unmapped index return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_trig_i | input | 1 | Receive level at or above trigger |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_full_i | input | 1 | Receive FIFO full |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_trig_i | input | 1 | Transmit level at or above trigger |
| rx_ovr_i | input | 1 | Receive overrun pulse |
| frame_err_i | input | 1 | Framing error pulse |
| par_err_i | input | 1 | Parity error pulse |
| rx_tmo_i | input | 1 | Receive timeout pulse |
| modem_i | input | 1 | Modem status change pulse |
| tx_ovr_i | input | 1 | Transmit overrun pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word index |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench uses the default 32-bit data width and a 6-bit word index. This reaches every mapped register and also leaves unmapped indices to probe. With full-width data, random write values exercise the upper mask bits. They also exercise the reserved sticky bits 11 and 13 and above, which can never be set. Random traffic over this small index space often makes a sticky clear land in the same cycle as a set of that bit. The same traffic makes enable and disable writes alternate with reads of the mask.

// File: rtl/uic_pkg.sv
package uic_pkg;
  // live flag word positions
  localparam int LV_RX_TRIG  = 0;
  localparam int LV_RX_EMPTY = 1;
  localparam int LV_RX_FULL  = 2;
  localparam int LV_TX_EMPTY = 3;
  localparam int LV_TX_FULL  = 4;
  localparam int LV_TX_TRIG  = 13;
  // sticky cause positions beyond the mirrored low field
  localparam int ST_LEVEL_W  = 5;
  localparam int ST_RX_OVR   = 5;
  localparam int ST_FRAME    = 6;
  localparam int ST_PARITY   = 7;
  localparam int ST_RX_TMO   = 8;
  localparam int ST_MODEM    = 9;
  localparam int ST_TX_TRIG  = 10;
  localparam int ST_TX_OVR   = 12;
endpackage

// File: rtl/uic_live_pack.sv
module uic_live_pack
  import uic_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [5:0]        lvl_i,   // {tx_trig, tx_full, tx_empty, rx_full, rx_empty, rx_trig}
  input  logic [5:0]        evt_i,   // {tx_ovr, modem, rx_tmo, parity, frame, rx_ovr}
  output logic [DATA_W-1:0] live_o,
  output logic [DATA_W-1:0] set_o
);
  always_comb begin
    live_o = '0;
    live_o[LV_RX_TRIG]  = lvl_i[0];
    live_o[LV_RX_EMPTY] = lvl_i[1];
    live_o[LV_RX_FULL]  = lvl_i[2];
    live_o[LV_TX_EMPTY] = lvl_i[3];
    live_o[LV_TX_FULL]  = lvl_i[4];
    live_o[LV_TX_TRIG]  = lvl_i[5];
  end

  always_comb begin
    set_o = '0;
    set_o[ST_LEVEL_W-1:0] = live_o[ST_LEVEL_W-1:0];
    set_o[ST_RX_OVR]  = evt_i[0];
    set_o[ST_FRAME]   = evt_i[1];
    set_o[ST_PARITY]  = evt_i[2];
    set_o[ST_RX_TMO]  = evt_i[3];
    set_o[ST_MODEM]   = evt_i[4];
    set_o[ST_TX_TRIG] = live_o[LV_TX_TRIG];
    set_o[ST_TX_OVR]  = evt_i[5];
  end
endmodule

// File: rtl/uic_mask.sv
module uic_mask #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en_i,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_o <= '0;
    else if (set_en_i) mask_o <= mask_o | val_i;
    else if (clr_en_i) mask_o <= mask_o & ~val_i;
  end
endmodule

// File: rtl/uic_sticky.sv
module uic_sticky #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] st_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_o[g] <= 1'b0;
      else if (set_i[g]) st_o[g] <= 1'b1;
      else if (clr_i[g]) st_o[g] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> st_o[g]);  // R9
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !st_o[g]);  // R8
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int              DATA_W  = 32,
  parameter int              ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] IDX_EN   = 6'h02,
  parameter logic [ADDR_W-1:0] IDX_DIS  = 6'h03,
  parameter logic [ADDR_W-1:0] IDX_MASK = 6'h04,
  parameter logic [ADDR_W-1:0] IDX_ST   = 6'h05,
  parameter logic [ADDR_W-1:0] IDX_LIVE = 6'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_trig_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  input  logic              tx_trig_i,
  input  logic              rx_ovr_i,
  input  logic              frame_err_i,
  input  logic              par_err_i,
  input  logic              rx_tmo_i,
  input  logic              modem_i,
  input  logic              tx_ovr_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] live_w, set_w, clr_w, mask_w, st_w;
  logic              wr_en, wr_dis, wr_st;

  assign wr_en  = bus_wr_i && (bus_addr_i == IDX_EN);
  assign wr_dis = bus_wr_i && (bus_addr_i == IDX_DIS);
  assign wr_st  = bus_wr_i && (bus_addr_i == IDX_ST);
  assign clr_w  = wr_st ? bus_wdata_i : '0;

  uic_live_pack #(.DATA_W(DATA_W)) u_pack (
    .lvl_i  ({tx_trig_i, tx_full_i, tx_empty_i, rx_full_i, rx_empty_i, rx_trig_i}),
    .evt_i  ({tx_ovr_i, modem_i, rx_tmo_i, par_err_i, frame_err_i, rx_ovr_i}),
    .live_o (live_w),
    .set_o  (set_w)
  );

  uic_mask #(.DATA_W(DATA_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (wr_en),
    .clr_en_i (wr_dis),
    .val_i    (bus_wdata_i),
    .mask_o   (mask_w)
  );

  uic_sticky #(.DATA_W(DATA_W)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_w),
    .clr_i (clr_w),
    .st_o  (st_w)
  );

  always_comb begin
    unique case (bus_addr_i)
      IDX_MASK: bus_rdata_o = mask_w;
      IDX_ST:   bus_rdata_o = st_w;
      IDX_LIVE: bus_rdata_o = live_w;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |(mask_w & st_w);

  AST_ENABLE_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mask_w & $past(bus_wdata_i)) == $past(bus_wdata_i)));  // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((mask_w & $past(bus_wdata_i)) == '0));  // R6
  AST_MASK_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == IDX_MASK) |=> $stable(mask_w));  // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> !irq_o);  // R10
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_trig, rx_empty, rx_full, tx_empty, tx_full, tx_trig;
  logic rx_ovr, frame_err, par_err, rx_tmo, modem, tx_ovr;
  logic bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string req = "R11";
  logic [DW-1:0] m_mask = '0, m_st = '0;

  always #(PERIOD/2) clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_trig_i(rx_trig), .rx_empty_i(rx_empty), .rx_full_i(rx_full),
    .tx_empty_i(tx_empty), .tx_full_i(tx_full), .tx_trig_i(tx_trig),
    .rx_ovr_i(rx_ovr), .frame_err_i(frame_err), .par_err_i(par_err),
    .rx_tmo_i(rx_tmo), .modem_i(modem), .tx_ovr_i(tx_ovr),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  function automatic logic [DW-1:0] ref_live();
    logic [DW-1:0] v = '0;
    v[0] = rx_trig; v[1] = rx_empty; v[2] = rx_full;
    v[3] = tx_empty; v[4] = tx_full; v[13] = tx_trig;
    return v;
  endfunction

  function automatic logic [DW-1:0] ref_set();
    logic [DW-1:0] v = '0;
    v[0] = rx_trig; v[1] = rx_empty; v[2] = rx_full;
    v[3] = tx_empty; v[4] = tx_full; v[10] = tx_trig;
    v[5] = rx_ovr; v[6] = frame_err; v[7] = par_err;
    v[8] = rx_tmo; v[9] = modem; v[12] = tx_ovr;
    return v;
  endfunction

  function automatic logic [DW-1:0] ref_read();
    case (bus_addr)
      6'h04:   return m_mask;
      6'h05:   return m_st;
      6'h0B:   return ref_live();
      default: return '0;
    endcase
  endfunction

  task automatic chk(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0h actual=%h expected=%h", r, bus_addr, act, exp);
    end
  endtask

  task automatic idle();
    {rx_trig, rx_empty, rx_full, tx_empty, tx_full, tx_trig} = '0;
    {rx_ovr, frame_err, par_err, rx_tmo, modem, tx_ovr} = '0;
    bus_wr = 0; bus_addr = 6'h05; bus_wdata = '0;
  endtask

  // inputs already driven after a negedge; compare then advance the model
  task automatic step();
    logic [DW-1:0] clr;
    #1;
    chk(req, bus_rdata, ref_read());
    chk("R10", {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, |(m_mask & m_st)});
    if (rst_n) begin
      clr = '0;
      if (bus_wr && bus_addr == 6'h02) m_mask = m_mask | bus_wdata;
      else if (bus_wr && bus_addr == 6'h03) m_mask = m_mask & ~bus_wdata;
      else if (bus_wr && bus_addr == 6'h05) clr = bus_wdata;
      m_st = (m_st & ~clr) | ref_set();
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step();
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, string r);
    req = r; bus_addr = a; step();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rx_empty = 1; tx_ovr = 1; bus_wr = 1; bus_addr = 6'h02; bus_wdata = '1;
    @(negedge clk);
    req = "R11"; step();              // inputs ignored during reset
    bus_addr = 6'h04; step();
    idle();
    rst_n = 1;
    rd(6'h05, "R11"); rd(6'h04, "R11");

    // R1: live flag word
    rx_trig = 1; rx_full = 1; tx_trig = 1;
    rd(6'h0B, "R1");
    idle(); tx_empty = 1; tx_full = 1; rx_empty = 1;
    rd(6'h0B, "R1");
    idle(); rd(6'h0B, "R1");
    wr(6'h05, '1); rd(6'h05, "R8");

    // R2: level bits mirrored
    rx_empty = 1; tx_full = 1; rd(6'h05, "R2");
    idle(); rd(6'h05, "R2");
    wr(6'h05, '1); rd(6'h05, "R8");

    // R3: transmit trigger lands at sticky bit 10
    tx_trig = 1; rd(6'h0B, "R3");
    idle(); rd(6'h05, "R3");
    wr(6'h05, 32'h0000_0400); rd(6'h05, "R8");

    // R4: each event pulse
    for (int k = 0; k < 6; k++) begin
      {tx_ovr, modem, rx_tmo, par_err, frame_err, rx_ovr} = 6'(1 << k);
      rd(6'h05, "R4");
      idle(); rd(6'h05, "R4");
    end

    // R8: partial clear
    wr(6'h05, 32'h0000_10A0); rd(6'h05, "R8");

    // R9: clear and set same bit same cycle
    rx_ovr = 1; wr(6'h05, 32'h0000_0020);
    idle(); rd(6'h05, "R9");

    // R5/R6/R7 mask access
    wr(6'h02, 32'h0000_0021); rd(6'h04, "R5");
    wr(6'h02, 32'h8000_0100); rd(6'h04, "R5");
    wr(6'h04, 32'h0000_0000); rd(6'h04, "R7");
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, "R7");
    wr(6'h03, 32'h0000_0001); rd(6'h04, "R6");
    rd(6'h05, "R10");                 // irq via bit 5 and bit 8
    wr(6'h05, '1); rd(6'h05, "R10");
    modem = 1; rd(6'h05, "R10"); idle();
    wr(6'h02, 32'h0000_0200); rd(6'h05, "R10");
    wr(6'h03, '1); rd(6'h04, "R6");

    // R12: write-only and unmapped indices read zero
    rd(6'h02, "R12"); rd(6'h03, "R12"); rd(6'h00, "R12"); rd(6'h3F, "R12");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] pick;
      {rx_trig, rx_empty, rx_full, tx_empty, tx_full, tx_trig} = 6'($urandom) & 6'($urandom);
      {rx_ovr, frame_err, par_err, rx_tmo, modem, tx_ovr} = 6'($urandom) & 6'($urandom) & 6'($urandom);
      pick = 6'($urandom_range(0, 7));
      case (pick)
        0: bus_addr = 6'h02; 1: bus_addr = 6'h03; 2: bus_addr = 6'h04;
        3: bus_addr = 6'h05; 4: bus_addr = 6'h0B; 5: bus_addr = 6'h05;
        6: bus_addr = 6'h04; default: bus_addr = 6'($urandom);
      endcase
      bus_wr = ($urandom_range(0, 2) == 0);
      bus_wdata = $urandom;
      case (bus_addr)
        6'h04: req = "R7"; 6'h05: req = "R8"; 6'h0B: req = "R1"; default: req = "R12";
      endcase
      step();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule